// File: doc/BRIEF.md
# One-Hot Bus Response Multiplexer

This block sits on the return path of a memory-mapped backplane. Each attached
device presents a response bundle made of a data word and a device-select
field. A one-hot select vector, with one bit per device, picks the bundle that
is forwarded to the bus master. The whole bundle is passed on, not only the
data word.

The selection is a flat AND-OR network: each bundle is masked by its own
select bit and all masked bundles are OR-ed together, so no input has priority
over another. An all-zero select yields an all-zero output. Several set select
bits yield the bitwise OR of the chosen bundles and raise an error flag. A
parameter chooses whether the result leaves the block at once or through one
output register. The address decoder that produces the select vector is not
part of this block.

Top module: `resp_mux`

## Requirements
- R1: With exactly one select bit set, `out_data` equals the data word of the device whose index is that bit's position, and `out_multi` is 0.
- R2: With exactly one select bit set, `out_dsel` equals the device-select field of that same device.
- R3: With no select bit set, `out_data`, `out_dsel` and `out_multi` are all zero.
- R4: With two or more select bits set, `out_data` and `out_dsel` are the bitwise OR of the fields of every selected device, and `out_multi` is 1.
- R5: With `REGISTERED` = 1, the outputs show, after a rising edge of `clk` at which `rst` is low, the result for the inputs present just before that edge: exactly one cycle of latency.
- R6: With `REGISTERED` = 1, a rising edge of `clk` with `rst` high sets all three outputs to zero, whatever the inputs are.
- R7: With `REGISTERED` = 0, the outputs follow the inputs in the same cycle with no clock edge in between.
- R8: Device i uses bits [i*DATA_W +: DATA_W] of `rsp_data` and bits [i*N_DEV +: N_DEV] of `rsp_dsel`; select bit i refers to device i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge (used when REGISTERED = 1) |
| rst | input | 1 | Synchronous active-high reset of the output register |
| sel | input | N_DEV | One-hot device select, bit i picks device i |
| rsp_data | input | N_DEV*DATA_W | Packed data words of all devices |
| rsp_dsel | input | N_DEV*N_DEV | Packed device-select fields of all devices |
| out_data | output | DATA_W | Forwarded data word |
| out_dsel | output | N_DEV | Forwarded device-select field |
| out_multi | output | 1 | High when more than one select bit is set |

## Verification
The bench builds two instances side by side. One uses the defaults, sixteen
devices with 32-bit data and the output register, which brings the one-cycle
latency and the mid-run reset within reach. The other uses five devices with
12-bit data and no register, so an odd device count that is not a power of two
and the same-cycle path are exercised too. Both see random one-hot, empty and
multi-bit select vectors, plus directed patterns on the first and last device
and on all select bits at once.

// File: rtl/rmux_pkg.sv
package rmux_pkg;

    localparam int DEF_N_DEV  = 16;
    localparam int DEF_DATA_W = 32;

    // Classification of a select vector.
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_ONE   = 2'd1,
        SEL_MULTI = 2'd2
    } sel_kind_e;

endpackage

// File: rtl/rmux_andor.sv
// Parallel AND-OR selection: every bundle is gated by its own select bit and
// all gated bundles are merged with OR. No input has priority.
module rmux_andor #(
    parameter int N_DEV  = 16,
    parameter int DATA_W = 32
) (
    input  logic [N_DEV-1:0]        sel,
    input  logic [N_DEV*DATA_W-1:0] rsp_data,
    input  logic [N_DEV*N_DEV-1:0]  rsp_dsel,
    output logic [DATA_W-1:0]       mux_data,
    output logic [N_DEV-1:0]        mux_dsel
);

    localparam int BUNDLE_W = DATA_W + N_DEV;

    logic [BUNDLE_W-1:0] gated [N_DEV];

    for (genvar g = 0; g < N_DEV; g++) begin : g_gate
        assign gated[g] = {rsp_dsel[g*N_DEV +: N_DEV], rsp_data[g*DATA_W +: DATA_W]}
                          & {BUNDLE_W{sel[g]}};
    end

    logic [BUNDLE_W-1:0] merged;

    // Starting from zero gives the defined all-zero result for an empty select.
    always_comb begin
        merged = '0;
        for (int i = 0; i < N_DEV; i++) begin
            merged = merged | gated[i];
        end
    end

    assign mux_data = merged[DATA_W-1:0];
    assign mux_dsel = merged[BUNDLE_W-1:DATA_W];

endmodule

// File: rtl/rmux_selchk.sv
// Counts the set select bits and classifies the vector.
module rmux_selchk
    import rmux_pkg::*;
#(
    parameter int N_DEV = 16
) (
    input  logic [N_DEV-1:0] sel,
    output sel_kind_e        kind,
    output logic             multi
);

    localparam int CNT_W = $clog2(N_DEV + 1);

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < N_DEV; i++) begin
            ones = ones + CNT_W'(sel[i]);
        end
    end

    always_comb begin
        if (ones == '0)
            kind = SEL_NONE;
        else if (ones == CNT_W'(1))
            kind = SEL_ONE;
        else
            kind = SEL_MULTI;
    end

    always_comb begin
        unique case (kind)
            SEL_NONE:  multi = 1'b0;
            SEL_ONE:   multi = 1'b0;
            SEL_MULTI: multi = 1'b1;
            default:   multi = 1'b0;
        endcase
    end

endmodule

// File: rtl/rmux_stage.sv
// Output stage: a plain wire or one register with synchronous reset.
module rmux_stage #(
    parameter int WIDTH      = 49,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else
                q <= d;
        end
    end else begin : g_wire
        logic unused_ok;
        assign unused_ok = clk ^ rst;
        assign q = d;
    end

endmodule

// File: rtl/resp_mux.sv
module resp_mux
    import rmux_pkg::*;
#(
    parameter int N_DEV      = DEF_N_DEV,
    parameter int DATA_W     = DEF_DATA_W,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_DEV-1:0]        sel,
    input  logic [N_DEV*DATA_W-1:0] rsp_data,
    input  logic [N_DEV*N_DEV-1:0]  rsp_dsel,
    output logic [DATA_W-1:0]       out_data,
    output logic [N_DEV-1:0]        out_dsel,
    output logic                    out_multi
);

    localparam int OUT_W = DATA_W + N_DEV + 1;

    logic [DATA_W-1:0] mux_data;
    logic [N_DEV-1:0]  mux_dsel;
    logic              mux_err;
    sel_kind_e         sel_kind;

    rmux_andor #(
        .N_DEV  (N_DEV),
        .DATA_W (DATA_W)
    ) u_andor (
        .sel      (sel),
        .rsp_data (rsp_data),
        .rsp_dsel (rsp_dsel),
        .mux_data (mux_data),
        .mux_dsel (mux_dsel)
    );

    rmux_selchk #(
        .N_DEV (N_DEV)
    ) u_selchk (
        .sel   (sel),
        .kind  (sel_kind),
        .multi (mux_err)
    );

    logic [OUT_W-1:0] stage_q;

    rmux_stage #(
        .WIDTH      (OUT_W),
        .REGISTERED (REGISTERED)
    ) u_stage (
        .clk (clk),
        .rst (rst),
        .d   ({mux_err, mux_dsel, mux_data}),
        .q   (stage_q)
    );

    assign out_data  = stage_q[DATA_W-1:0];
    assign out_dsel  = stage_q[DATA_W +: N_DEV];
    assign out_multi = stage_q[OUT_W-1];

endmodule

// File: rtl/rmux_chk.sv
module rmux_chk #(
    parameter int N_DEV      = 16,
    parameter int DATA_W     = 32,
    parameter bit REGISTERED = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [N_DEV-1:0]  sel,
    input logic [DATA_W-1:0] mux_data,
    input logic [N_DEV-1:0]  mux_dsel,
    input logic              mux_err,
    input logic [DATA_W-1:0] out_data,
    input logic [N_DEV-1:0]  out_dsel,
    input logic              out_multi
);

    // R3
    empty_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> (mux_data == '0 && mux_dsel == '0 && !mux_err));

    // R4
    multi_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(sel) > 1) |-> mux_err);

    // R1
    single_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel) |-> !mux_err);

    if (REGISTERED) begin : g_reg_chk
        // R5
        one_cycle_latency_chk: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> (out_data == $past(mux_data) && out_dsel == $past(mux_dsel)
                             && out_multi == $past(mux_err)));

        // R6
        reset_clear_chk: assert property (@(posedge clk)
            $past(rst) |-> (out_data == '0 && out_dsel == '0 && !out_multi));
    end else begin : g_comb_chk
        // R7
        same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
            (out_data == mux_data && out_dsel == mux_dsel && out_multi == mux_err));
    end

endmodule

bind resp_mux rmux_chk #(
    .N_DEV      (N_DEV),
    .DATA_W     (DATA_W),
    .REGISTERED (REGISTERED)
) u_rmux_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .mux_data  (mux_data),
    .mux_dsel  (mux_dsel),
    .mux_err   (mux_err),
    .out_data  (out_data),
    .out_dsel  (out_dsel),
    .out_multi (out_multi)
);

// File: tb/tb_resp_mux.sv
`timescale 1ns/1ps
module tb_resp_mux;

    localparam int NA = 16, DA = 32;   // registered instance
    localparam int NB = 5,  DB = 12;   // combinational instance

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;             // 50 MHz

    logic [NA-1:0]    sel_a = '0;
    logic [NA*DA-1:0] dat_a = '0;
    logic [NA*NA-1:0] dsl_a = '0;
    logic [DA-1:0]    od_a;
    logic [NA-1:0]    os_a;
    logic             om_a;

    logic [NB-1:0]    sel_b = '0;
    logic [NB*DB-1:0] dat_b = '0;
    logic [NB*NB-1:0] dsl_b = '0;
    logic [DB-1:0]    od_b;
    logic [NB-1:0]    os_b;
    logic             om_b;

    resp_mux #(.N_DEV(NA), .DATA_W(DA), .REGISTERED(1'b1)) dut (
        .clk(clk), .rst(rst), .sel(sel_a), .rsp_data(dat_a), .rsp_dsel(dsl_a),
        .out_data(od_a), .out_dsel(os_a), .out_multi(om_a));

    resp_mux #(.N_DEV(NB), .DATA_W(DB), .REGISTERED(1'b0)) dut_c (
        .clk(clk), .rst(rst), .sel(sel_b), .rsp_data(dat_b), .rsp_dsel(dsl_b),
        .out_data(od_b), .out_dsel(os_b), .out_multi(om_b));

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DA-1:0] ed_a; logic [NA-1:0] es_a; logic em_a;
    logic [DB-1:0] ed_b; logic [NB-1:0] es_b; logic em_b;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // Expected values straight from R1..R4 and R8.
    task automatic expect_a();
        int n = 0;
        ed_a = '0; es_a = '0;
        for (int i = 0; i < NA; i++) begin
            if (sel_a[i]) begin
                ed_a |= dat_a[i*DA +: DA];
                es_a |= dsl_a[i*NA +: NA];
                n++;
            end
        end
        em_a = (n > 1);
    endtask

    task automatic expect_b();
        int n = 0;
        ed_b = '0; es_b = '0;
        for (int i = 0; i < NB; i++) begin
            if (sel_b[i]) begin
                ed_b |= dat_b[i*DB +: DB];
                es_b |= dsl_b[i*NB +: NB];
                n++;
            end
        end
        em_b = (n > 1);
    endtask

    function automatic string tag_of(input int ones);
        if (ones == 0) return "R3";
        if (ones == 1) return "R1";
        return "R4";
    endfunction

    task automatic fill_random();
        for (int i = 0; i < NA*DA/32; i++) dat_a[i*32 +: 32] = $urandom;
        for (int i = 0; i < NA*NA/32; i++) dsl_a[i*32 +: 32] = $urandom;
        dat_b = {$urandom, $urandom};
        dsl_b = 25'($urandom);
    endtask

    function automatic logic [31:0] pick_sel(input int n);
        int mode = $urandom % 8;
        logic [31:0] s;
        if (mode == 0) return '0;
        if (mode <= 2) begin
            s = $urandom;
            s[$urandom % n] = 1'b1;
            s[($urandom % (n - 1) + 1 + 0) % n] = 1'b1;
            s = s & ((32'd1 << n) - 1);
            if ($countones(s) < 2) s = 32'd3;
            return s;
        end
        return 32'd1 << ($urandom % n);
    endfunction

    // One step: drive at negedge, check combinational instance, then the
    // registered instance just after the next rising edge.
    task automatic step(input logic [NA-1:0] sa, input logic [NB-1:0] sb);
        @(negedge clk);
        sel_a = sa; sel_b = sb;
        expect_a(); expect_b();
        #1;
        chk({tag_of($countones(sb)), " R7 R8 data"}, 64'(od_b), 64'(ed_b));
        chk({tag_of($countones(sb)), " R2 R7 dsel"}, 64'(os_b), 64'(es_b));
        chk({tag_of($countones(sb)), " R7 flag"},    64'(om_b), 64'(em_b));
        @(posedge clk);
        #1;
        chk({tag_of($countones(sa)), " R5 R8 data"}, 64'(od_a), 64'(ed_a));
        chk({tag_of($countones(sa)), " R2 R5 dsel"}, 64'(os_a), 64'(es_a));
        chk({tag_of($countones(sa)), " R5 flag"},    64'(om_a), 64'(em_a));
    endtask

    initial begin
        void'($urandom(32'd20160819));
        fill_random();
        sel_a = '1; sel_b = '1;
        repeat (3) @(posedge clk);
        #1;
        // R6: reset clears the registered outputs even with inputs active
        chk("R6 data", 64'(od_a), 64'd0);
        chk("R6 dsel", 64'(os_a), 64'd0);
        chk("R6 flag", 64'(om_a), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // Directed corners: first device, last device, none, all.
        step(NA'(1), NB'(1));
        step(NA'(1) << (NA-1), NB'(1) << (NB-1));
        step('0, '0);
        step('1, '1);

        for (int k = 0; k < 400; k++) begin
            fill_random();
            step(NA'(pick_sel(NA)), NB'(pick_sel(NB)));
            if (k == 200) begin
                // R6: mid-run reset with a live one-hot select
                @(negedge clk);
                rst = 1'b1;
                sel_a = NA'(1) << 3;
                @(posedge clk);
                #1;
                chk("R6 mid data", 64'(od_a), 64'd0);
                chk("R6 mid dsel", 64'(os_a), 64'd0);
                @(negedge clk);
                rst = 1'b0;
            end
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule